// File: doc/BRIEF.md
# Boot-Masked Region Base Registers

This block holds four 32-bit region base registers of the kind a host assigns during bus enumeration. Each register takes all of its character from a 32-bit mask word: the mask sets which address bits the host can write, the read-only attribute bits the host sees, the size of the region and the width of the add-on data bus behind it. The four mask words arrive once after reset on a word stream from a boot-memory reader. The first accepted word goes to region 0, the next to region 1, and so on. Until all four words are in, every region stays disabled.

The host sizes a region by writing all ones to it and reading it back. The low-order zero bits in the result give the size. It then writes the assigned base. Bits 31:30 of the mask carry a private bus-width code, and a code of 00 turns the region off. On host reads those two bits always copy bit 29, so no region can exceed 512 MB. For each region the block decodes the mask into several flags and codes. It also compares an incoming access address against each region and raises a hit line when the address, the access type and the enables all match.

The boot stream uses valid/ready. A word moves only on a cycle where both `boot_valid` and `boot_ready` are high. `boot_ready` stays high until the fourth word is taken and then stays low until reset, so a producer holding `boot_valid` afterwards is stalled forever and loses nothing already loaded. Configuration reads have a one-cycle latency: `cfg_rvalid` rises the cycle after `cfg_rd` and carries the data for that read.

Top module: `bar_bank`

## Requirements
- R1: Boot words move on cycles with `boot_valid` and `boot_ready` both high. The k-th accepted word becomes the mask of region k. After four words, `load_done` goes high and stays high, `boot_ready` goes low, and later words change nothing. While `load_done` is low, no hit is raised.
- R2: Mask bit 0 set means an I/O region (`region_io`=1); clear means memory. A memory region reports mask bits 2:1 on `region_loc` (00 any 32-bit address, 01 below 1 MB, 10 64-bit, 11 reserved) and mask bit 3 on `region_pref`. An I/O region reports location 00 and prefetch 0.
- R3: `region_width` reports mask bits 31:30 (00 off, 01 8-bit, 10 16-bit, 11 32-bit). Code 00 sets `region_off` whatever the other bits hold.
- R4: On every read of an enabled region, bits 31 and 30 equal bit 29.
- R5: A read returns 1 where the stored address bit is 1 or the bit is an attribute bit whose mask bit is 1. After an all-ones write, mask BFFFF002h reads FFFFF002h (4 KB, below 1 MB, 16-bit, not prefetchable) and FFFFFF81h reads FFFFFF81h (128-byte I/O, 32-bit).
- R6: Attribute bits (1:0 for I/O, 3:0 for memory) ignore writes and return their mask values. A write changes only address bits 29 down to the attribute field whose mask bit is 1.
- R7: An off region reads as 00000000h and never raises its hit.
- R8: A region hits when `acc_addr` matches the stored base in every writable address bit, and its bits 31:30 equal the mirrored bit 29. The access type (`acc_io`) must match the region type, and `io_space_en` or `mem_space_en` (whichever applies) must be high.
- R9: A memory region with location 10 or 11 sets `region_loc_bad` and never hits.
- R10: Reset clears all stored bases and all masks, drops `load_done` and raises `boot_ready`. A reload after reset starts again at region 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_valid | input | 1 | Boot mask word valid |
| boot_ready | output | 1 | Block accepts a boot word |
| boot_data | input | 32 | Boot mask word |
| load_done | output | 1 | All four masks loaded |
| cfg_wr | input | 1 | Host write strobe |
| cfg_rd | input | 1 | Host read strobe |
| cfg_sel | input | 2 | Region index for read or write |
| cfg_wdata | input | 32 | Host write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| cfg_rdata | output | 32 | Read data |
| acc_addr | input | 32 | Incoming access address |
| acc_io | input | 1 | 1 for an I/O access, 0 for memory |
| mem_space_en | input | 1 | Memory decoding enable |
| io_space_en | input | 1 | I/O decoding enable |
| region_hit | output | 4 | Per-region address hit |
| region_off | output | 4 | Per-region disabled flag |
| region_io | output | 4 | Per-region I/O type flag |
| region_loc | output | 8 | Per-region location code, 2 bits each, region 0 lowest |
| region_pref | output | 4 | Per-region prefetchable flag |
| region_width | output | 8 | Per-region bus-width code, 2 bits each, region 0 lowest |
| region_loc_bad | output | 4 | Per-region invalid memory location flag |

## Verification
The assertions check these rules on every cycle:
- the handshake rules of the boot stream, and that `load_done` stays high once set;
- the one-cycle read latency and the bit-29 mirror on every returned word;
- that no off region, no region with a bad location and no region before load ever raises a hit;
- that a hit only ever occurs with the matching space enable.

The bench scenarios are the only way to show the rest:
- mask values landing in the right region;
- the exact sizing readbacks and the read-only attribute bits;
- base assignment and the address windows of the hits, including the boundary one byte past each region and bits 31:30 above a region;
- that a reset followed by a reload starts again cleanly.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int BAR_W      = 32;
  localparam int MIRROR_BIT = BAR_W - 3;
  localparam int ADDR_HI_W  = MIRROR_BIT + 1;
  localparam int IO_ATTR_W  = 2;
  localparam int MEM_ATTR_W = 4;

  typedef enum logic [1:0] {
    LOC_ANY32 = 2'b00,
    LOC_LOW1M = 2'b01,
    LOC_ANY64 = 2'b10,
    LOC_RSVD  = 2'b11
  } loc_e;

  typedef enum logic [1:0] {
    BW_OFF = 2'b00,
    BW_8   = 2'b01,
    BW_16  = 2'b10,
    BW_32  = 2'b11
  } bw_e;

  typedef struct packed {
    logic off;
    logic is_io;
    loc_e loc;
    logic pref;
    bw_e  width;
    logic loc_bad;
  } bar_attr_t;

  function automatic bar_attr_t decode_mask(input logic [BAR_W-1:0] m);
    bar_attr_t a;
    a.width   = bw_e'(m[BAR_W-1 -: 2]);
    a.off     = (m[BAR_W-1 -: 2] == 2'b00);
    a.is_io   = m[0];
    a.loc     = m[0] ? LOC_ANY32 : loc_e'(m[2:1]);
    a.pref    = ~m[0] & m[3];
    a.loc_bad = ~m[0] & m[2];
    return a;
  endfunction

  function automatic logic [ADDR_HI_W-1:0] attr_field(input logic is_io);
    logic [ADDR_HI_W-1:0] f;
    f = '0;
    if (is_io) f[IO_ATTR_W-1:0]  = '1;
    else       f[MEM_ATTR_W-1:0] = '1;
    return f;
  endfunction
endpackage

// File: rtl/bar_boot_loader.sv
module bar_boot_loader #(
  parameter int NUM_REGIONS = 4,
  parameter int WORD_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boot_valid,
  output logic                   boot_ready,
  input  logic [WORD_W-1:0]      boot_data,
  output logic [NUM_REGIONS-1:0] ld_en,
  output logic [WORD_W-1:0]      ld_word,
  output logic                   done
);
  localparam int CNT_W = $clog2(NUM_REGIONS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign done       = (cnt_q == CNT_W'(NUM_REGIONS));
  assign boot_ready = ~done;
  assign take       = boot_valid & boot_ready;
  assign ld_word    = boot_data;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_en
    assign ld_en[i] = take & (cnt_q == CNT_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (take) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bar_region.sv
module bar_region
  import bar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [BAR_W-1:0] ld_word,
  input  logic             wr_en,
  input  logic [BAR_W-1:0] wr_data,
  input  logic [BAR_W-1:0] acc_addr,
  input  logic             acc_io,
  input  logic             mem_en,
  input  logic             io_en,
  output logic [BAR_W-1:0] rd_word,
  output logic             hit,
  output bar_attr_t        attr
);
  logic [BAR_W-1:0]     mask_q;
  logic [ADDR_HI_W-1:0] base_q;
  logic [ADDR_HI_W-1:0] attr_bits;
  logic [ADDR_HI_W-1:0] wmask;
  logic [BAR_W-1:0]     cmp_mask;
  logic [BAR_W-1:0]     cmp_ref;
  logic                 mirror;
  logic                 type_ok;

  assign attr      = decode_mask(mask_q);
  assign attr_bits = attr_field(attr.is_io);
  assign wmask     = mask_q[ADDR_HI_W-1:0] & ~attr_bits;
  assign mirror    = base_q[MIRROR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else begin
      if (ld_en) mask_q <= ld_word;
      if (wr_en) base_q <= wr_data[ADDR_HI_W-1:0] & wmask;
    end
  end

  always_comb begin
    if (attr.off) rd_word = '0;
    else          rd_word = {mirror, mirror,
                             base_q | (mask_q[ADDR_HI_W-1:0] & attr_bits)};
  end

  assign cmp_mask = {2'b11, wmask};
  assign cmp_ref  = {mirror, mirror, base_q};
  assign type_ok  = attr.is_io ? (acc_io & io_en) : (~acc_io & mem_en);
  assign hit      = ~attr.off & ~attr.loc_bad & type_ok &
                    (((acc_addr ^ cmp_ref) & cmp_mask) == '0);
endmodule

// File: rtl/bar_bank.sv
module bar_bank
  import bar_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int SEL_W      = $clog2(NUM_REGIONS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     boot_valid,
  output logic                     boot_ready,
  input  logic [BAR_W-1:0]         boot_data,
  output logic                     load_done,
  input  logic                     cfg_wr,
  input  logic                     cfg_rd,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [BAR_W-1:0]         cfg_wdata,
  output logic                     cfg_rvalid,
  output logic [BAR_W-1:0]         cfg_rdata,
  input  logic [BAR_W-1:0]         acc_addr,
  input  logic                     acc_io,
  input  logic                     mem_space_en,
  input  logic                     io_space_en,
  output logic [NUM_REGIONS-1:0]   region_hit,
  output logic [NUM_REGIONS-1:0]   region_off,
  output logic [NUM_REGIONS-1:0]   region_io,
  output logic [2*NUM_REGIONS-1:0] region_loc,
  output logic [NUM_REGIONS-1:0]   region_pref,
  output logic [2*NUM_REGIONS-1:0] region_width,
  output logic [NUM_REGIONS-1:0]   region_loc_bad
);
  logic [NUM_REGIONS-1:0] ld_en;
  logic [BAR_W-1:0]       ld_word;
  logic [BAR_W-1:0]       rd_words [NUM_REGIONS];
  logic                   hit_raw  [NUM_REGIONS];
  bar_attr_t              attrs    [NUM_REGIONS];

  bar_boot_loader #(.NUM_REGIONS(NUM_REGIONS), .WORD_W(BAR_W)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_valid (boot_valid),
    .boot_ready (boot_ready),
    .boot_data  (boot_data),
    .ld_en      (ld_en),
    .ld_word    (ld_word),
    .done       (load_done)
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic wr_hit;
    assign wr_hit = cfg_wr & load_done & (cfg_sel == SEL_W'(i));

    bar_region u_region (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en[i]),
      .ld_word  (ld_word),
      .wr_en    (wr_hit),
      .wr_data  (cfg_wdata),
      .acc_addr (acc_addr),
      .acc_io   (acc_io),
      .mem_en   (mem_space_en),
      .io_en    (io_space_en),
      .rd_word  (rd_words[i]),
      .hit      (hit_raw[i]),
      .attr     (attrs[i])
    );

    assign region_hit[i]          = hit_raw[i] & load_done;
    assign region_off[i]          = attrs[i].off;
    assign region_io[i]           = attrs[i].is_io;
    assign region_loc[2*i +: 2]   = attrs[i].loc;
    assign region_pref[i]         = attrs[i].pref;
    assign region_width[2*i +: 2] = attrs[i].width;
    assign region_loc_bad[i]      = attrs[i].loc_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_words[cfg_sel];
    end
  end
endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk #(
  parameter int NUM_REGIONS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   boot_valid,
  input logic                   boot_ready,
  input logic                   load_done,
  input logic                   cfg_rd,
  input logic                   cfg_rvalid,
  input logic [31:0]            cfg_rdata,
  input logic                   acc_io,
  input logic                   mem_space_en,
  input logic                   io_space_en,
  input logic [NUM_REGIONS-1:0] region_hit,
  input logic [NUM_REGIONS-1:0] region_off,
  input logic [NUM_REGIONS-1:0] region_loc_bad
);
  AST_READY_LOW_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !boot_ready); // R1
  AST_LOAD_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done); // R1
  AST_NO_HIT_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> (region_hit == '0)); // R1
  AST_STALLED_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_valid && !boot_ready) |=> !boot_ready); // R1
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid); // R5
  AST_MIRROR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> (cfg_rdata[31] == cfg_rdata[29] && cfg_rdata[30] == cfg_rdata[29])); // R4
  AST_OFF_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (region_hit & region_off) == '0); // R7
  AST_BAD_LOC_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (region_hit & region_loc_bad) == '0); // R9
  AST_IO_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (|region_hit && acc_io) |-> io_space_en); // R8
  AST_MEM_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (|region_hit && !acc_io) |-> mem_space_en); // R8
endmodule

bind bar_bank bar_bank_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .boot_valid     (boot_valid),
  .boot_ready     (boot_ready),
  .load_done      (load_done),
  .cfg_rd         (cfg_rd),
  .cfg_rvalid     (cfg_rvalid),
  .cfg_rdata      (cfg_rdata),
  .acc_io         (acc_io),
  .mem_space_en   (mem_space_en),
  .io_space_en    (io_space_en),
  .region_hit     (region_hit),
  .region_off     (region_off),
  .region_loc_bad (region_loc_bad)
);

// File: tb/bar_bank_tb.sv
module bar_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_valid = 1'b0;
  logic        boot_ready;
  logic [31:0] boot_data = '0;
  logic        load_done;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_addr = '0;
  logic        acc_io = 1'b0;
  logic        mem_space_en = 1'b1;
  logic        io_space_en = 1'b1;
  logic [3:0]  region_hit, region_off, region_io, region_pref, region_loc_bad;
  logic [7:0]  region_loc, region_width;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  bar_bank u_dut (
    .clk(clk), .rst_n(rst_n), .boot_valid(boot_valid), .boot_ready(boot_ready),
    .boot_data(boot_data), .load_done(load_done), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid),
    .cfg_rdata(cfg_rdata), .acc_addr(acc_addr), .acc_io(acc_io),
    .mem_space_en(mem_space_en), .io_space_en(io_space_en),
    .region_hit(region_hit), .region_off(region_off), .region_io(region_io),
    .region_loc(region_loc), .region_pref(region_pref),
    .region_width(region_width), .region_loc_bad(region_loc_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && cfg_rvalid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R5: actual %h expected no read", cfg_rdata);
      end else begin
        chk(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic boot_word(input logic [31:0] w);
    boot_valid = 1'b1;
    boot_data  = w;
    while (!boot_ready) @(negedge clk);
    @(negedge clk);
    boot_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] s, input logic [31:0] exp, input string req);
    cfg_rd = 1'b1; cfg_sel = s;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    cfg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input logic [31:0] a, input logic io, input logic [3:0] exp, input string req);
    acc_addr = a; acc_io = io;
    #1;
    chk(req, {28'h0, region_hit}, {28'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // reset state
    chk("R10 load_done", {31'h0, load_done}, 32'h0);
    chk("R10 boot_ready", {31'h0, boot_ready}, 32'h1);
    chk("R1 off before load", {28'h0, region_off}, 32'hF);
    cfg_read(2'd0, 32'h0, "R1 read before load");

    boot_word(32'hBFFFF002);
    boot_word(32'h30000000);
    boot_word(32'hFFFFFF81);
    chk("R1 not done after three", {31'h0, load_done}, 32'h0);
    boot_word(32'h5FF00008);
    chk("R1 done", {31'h0, load_done}, 32'h1);
    chk("R1 ready low", {31'h0, boot_ready}, 32'h0);

    // extra word must be stalled and ignored
    boot_valid = 1'b1; boot_data = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 stalled ready", {31'h0, boot_ready}, 32'h0);
    boot_valid = 1'b0;
    chk("R1 extra word ignored", {24'h0, region_width}, 32'h72);

    // decode: width r0=10 r1=00 r2=11 r3=01
    chk("R3 width codes", {24'h0, region_width}, 32'h72);
    chk("R3 off flags", {28'h0, region_off}, 32'h2);
    chk("R2 io flags", {28'h0, region_io}, 32'h4);
    chk("R2 loc codes", {24'h0, region_loc}, 32'h01);
    chk("R2 pref flags", {28'h0, region_pref}, 32'h8);
    chk("R9 no bad loc", {28'h0, region_loc_bad}, 32'h0);

    // attribute bits with zero base
    cfg_read(2'd0, 32'h00000002, "R6 r0 attr");
    cfg_read(2'd2, 32'h00000001, "R6 r2 attr");
    cfg_read(2'd3, 32'h00000008, "R6 r3 attr");

    // sizing
    for (int i = 0; i < 4; i++) cfg_write(2'(i), 32'hFFFFFFFF);
    cfg_read(2'd0, 32'hFFFFF002, "R5 size r0");
    cfg_read(2'd1, 32'h00000000, "R7 off r1");
    cfg_read(2'd2, 32'hFFFFFF81, "R5 size r2");
    cfg_read(2'd3, 32'h1FF00008, "R4 mirror zero r3");

    // read-only attributes
    cfg_write(2'd2, 32'hFFFFFFFC);
    cfg_read(2'd2, 32'hFFFFFF81, "R6 r2 bit0 kept");
    cfg_write(2'd0, 32'h0000000D);
    cfg_read(2'd0, 32'h00000002, "R6 r0 low bits kept");

    // base assignment
    cfg_write(2'd0, 32'h000C0000);
    cfg_write(2'd2, 32'h0000E000);
    cfg_write(2'd3, 32'h12300000);
    cfg_read(2'd0, 32'h000C0002, "R5 r0 base");
    cfg_read(2'd2, 32'h0000E001, "R5 r2 base");
    cfg_read(2'd3, 32'h12300008, "R5 r3 base");

    // hits
    probe(32'h000C0123, 1'b0, 4'b0001, "R8 r0 hit");
    probe(32'h000C1000, 1'b0, 4'b0000, "R8 r0 past end");
    probe(32'h0000E07F, 1'b1, 4'b0100, "R8 r2 io hit");
    probe(32'h0000E080, 1'b1, 4'b0000, "R8 r2 past end");
    probe(32'h0000E07F, 1'b0, 4'b0000, "R8 type mismatch");
    probe(32'h000C0123, 1'b1, 4'b0000, "R8 io to mem region");
    probe(32'h123ABCDE, 1'b0, 4'b1000, "R8 r3 hit");
    probe(32'h523ABCDE, 1'b0, 4'b0000, "R8 high bits differ");
    mem_space_en = 1'b0;
    probe(32'h000C0123, 1'b0, 4'b0000, "R8 mem disabled");
    mem_space_en = 1'b1;
    io_space_en = 1'b0;
    probe(32'h0000E07F, 1'b1, 4'b0000, "R8 io disabled");
    io_space_en = 1'b1;
    probe(32'h00000000, 1'b0, 4'b0000, "R7 off region silent");

    // bit 29 mirror
    cfg_write(2'd0, 32'h20000000);
    cfg_read(2'd0, 32'hE0000002, "R4 mirror one");
    probe(32'hE0000010, 1'b0, 4'b0001, "R4 R8 mirrored hit");
    probe(32'h20000010, 1'b0, 4'b0000, "R4 R8 unmirrored miss");

    // reset and reload with invalid locations
    @(negedge clk);
    do_reset();
    chk("R10 done cleared", {31'h0, load_done}, 32'h0);
    boot_word(32'hFFFF0004);
    boot_word(32'hFFFF0006);
    boot_word(32'h40000001);
    boot_word(32'h00000000);
    cfg_read(2'd0, 32'h00000004, "R10 base cleared");
    chk("R9 bad loc flags", {28'h0, region_loc_bad}, 32'h3);
    chk("R2 loc after reload", {24'h0, region_loc}, 32'h0E);
    chk("R3 r3 off", {28'h0, region_off}, 32'h8);
    cfg_write(2'd0, 32'hFFFFFFFF);
    cfg_read(2'd0, 32'hFFFF0004, "R9 r0 size");
    probe(32'hFFFF0000, 1'b0, 4'b0000, "R9 bad loc no hit");

    repeat (3) @(negedge clk);
    chk("R5 all reads returned", exp_q.size(), 32'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule